// File: doc/BRIEF.md
# Converter Host Control and Readout

This block sits between a host processor and a 12-bit conversion engine. Five host control lines feed it: a chip enable, an active-low chip select, a read/convert line, a byte-address bit and a word/byte format select. The block resynchronises these lines to its clock. It turns them into a single-cycle start request for the engine and records whether that conversion is short (8 bits) or full length (12 bits). The engine appears only through its busy flag and its result word.

On the read side the block drives 12 data lines and a separate enable for each line. The enables stand in for the tri-state control of a shared bus. A 16-bit host reads the whole word at once. An 8-bit host reads two left-justified bytes, and the byte-address bit selects which byte is on the bus. The block never enables both bytes at the same moment. Tying chip enable and format high, and chip select and the address bit low, gives stand-alone use, where the read/convert line alone starts conversions and reads results.

Top module: `adc_host_ctrl`

## Requirements
- R1: A start pulse is issued when chip enable is high, chip select is low and read/convert is low at the same time. Whichever of the three conditions is met last causes the start, whether it is chip enable, chip select or read/convert.
- R2: The address bit is captured at the start event. When 1 is captured, `short_cvt_o` = 1 (8-bit conversion). When 0 is captured, `short_cvt_o` = 0 (12-bit conversion).
- R3: A start condition that arises while `busy_i` is high produces no start pulse, and no start pulse follows later from that event.
- R4: `start_o` is a pulse one cycle wide. A start condition held for any length of time produces exactly one pulse.
- R5: `short_cvt_o` keeps its value from the start event until busy falls, even when the address bit toggles during the conversion.
- R6: All 12 data enables are 0, and the data lines are 0, unless read/convert is high, busy is low, chip enable is high and chip select is low.
- R7: When the format select is high and a read is enabled, all 12 enables are 1 and `data_o` equals `result_i`. The address bit has no effect in this mode.
- R8: When the format select is low, the address bit is 0 and a read is enabled, only enables 11..4 are 1, and lines 11..4 carry result bits 11..4. Every other line reads 0.
- R9: When the format select is low, the address bit is 1 and a read is enabled, only enables 7..0 are 1. Lines 7..4 are forced to 0, lines 3..0 carry result bits 3..0, and lines 11..8 are disabled.
- R10: When the readout changes from one byte to the other, at least one cycle with all enables at 0 separates them. The two bytes are never enabled in adjacent cycles.
- R11: With chip enable and format select tied high, and chip select and the address bit tied low, a low pulse on read/convert starts a 12-bit conversion. The full word is readable once read/convert is high and busy is low.
- R12: During and right after reset, `start_o`, `short_cvt_o` and every enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Chip enable, active high |
| chip_sel_ni | input | 1 | Chip select, active low |
| rd_cvt_i | input | 1 | High to read, low to convert |
| byte_sel_i | input | 1 | Byte address; also sets conversion length at start |
| word_mode_i | input | 1 | High for full-word readout, low for two-byte readout |
| busy_i | input | 1 | Conversion engine busy flag |
| result_i | input | 12 | Conversion result from the engine |
| start_o | output | 1 | One-cycle start request to the engine |
| short_cvt_o | output | 1 | Latched length: 1 for 8-bit, 0 for 12-bit |
| data_o | output | 12 | Read data lines, 0 where disabled |
| data_oe_o | output | 12 | Per-line output enable |

## Verification
The hardest case to reach from the ports is a fresh rising edge of the start condition that lands inside an active conversion. The bench first starts an 8-bit conversion. With its engine model still holding busy, it drops read/convert again and toggles the address bit. Its scoreboard then confirms that no second start appears, both during the conversion and after busy falls, and that the latched length is unchanged. For the byte handover, the bench samples the enables on every cycle after the address bit flips. It requires a cycle with all enables off before the other byte appears.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    RD_OFF  = 2'd0,
    RD_WORD = 2'd1,
    RD_HI   = 2'd2,
    RD_LO   = 2'd3
  } rd_mode_e;

  typedef struct packed {
    logic ce;
    logic cs_n;
    logic rc;
    logic a0;
    logic word;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/adc_ctrl_sync.sv
module adc_ctrl_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/adc_start_det.sv
module adc_start_det
  import adc_host_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  busy_i,
  output logic  start_o,
  output logic  short_o
);
  logic cond, cond_q, fire;
  logic start_q, short_q;

  // all three enabling terms together; last one to arrive makes the edge
  assign cond = ctrl_i.ce & ~ctrl_i.cs_n & ~ctrl_i.rc;
  assign fire = cond & ~cond_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q  <= 1'b0;
      start_q <= 1'b0;
      short_q <= 1'b0;
    end else begin
      cond_q  <= cond;
      start_q <= fire;
      if (fire) short_q <= ctrl_i.a0;
    end
  end

  assign start_o = start_q;
  assign short_o = short_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_i));
  // R5
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(short_o));
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_host_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  localparam int unsigned NIB   = DATA_W / 3;
  localparam int unsigned N_NIB = 3;

  rd_mode_e want, nxt, cur_q;
  logic     read_ok;
  logic [N_NIB-1:0] nib_en;

  assign read_ok = ctrl_i.rc & ~busy_i & ctrl_i.ce & ~ctrl_i.cs_n;

  always_comb begin
    if (!read_ok)         want = RD_OFF;
    else if (ctrl_i.word) want = RD_WORD;
    else if (ctrl_i.a0)   want = RD_LO;
    else                  want = RD_HI;
  end

  // break-before-make: any switch between two driving modes passes through OFF
  always_comb begin
    if (cur_q != RD_OFF && want != RD_OFF && want != cur_q) nxt = RD_OFF;
    else                                                     nxt = want;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= RD_OFF;
    else         cur_q <= nxt;
  end

  always_comb begin
    unique case (cur_q)
      RD_WORD: nib_en = 3'b111;
      RD_HI:   nib_en = 3'b110;
      RD_LO:   nib_en = 3'b011;
      default: nib_en = 3'b000;
    endcase
  end

  for (genvar n = 0; n < N_NIB; n++) begin : g_nib
    logic force_zero;
    // in low-byte mode the middle nibble pads the second byte with zeros
    assign force_zero = (n == 1) && (cur_q == RD_LO);
    assign data_oe_o[n*NIB +: NIB] = {NIB{nib_en[n]}};
    assign data_o[n*NIB +: NIB]    = (nib_en[n] && !force_zero) ?
                                     result_i[n*NIB +: NIB] : '0;
  end

  // R10
  bbm_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == RD_LO) |-> ($past(cur_q) != RD_HI));
  // R10
  bbm_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == RD_HI) |-> ($past(cur_q) != RD_LO));
  // R6
  oe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|data_oe_o) |-> !$past(busy_i));
  // R9
  lo_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|data_oe_o[NIB-1:0]) && !data_oe_o[DATA_W-1]) |-> (data_o[2*NIB-1:NIB] == '0));
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              chip_sel_ni,
  input  logic              rd_cvt_i,
  input  logic              byte_sel_i,
  input  logic              word_mode_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              start_o,
  output logic              short_cvt_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  ctrl_t ctrl_raw, ctrl_s;

  assign ctrl_raw = '{ce: chip_en_i, cs_n: chip_sel_ni, rc: rd_cvt_i,
                      a0: byte_sel_i, word: word_mode_i};

  adc_ctrl_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_raw),
    .q_o   (ctrl_s)
  );

  adc_start_det u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl_s),
    .busy_i (busy_i),
    .start_o(start_o),
    .short_o(short_cvt_o)
  );

  adc_read_mux #(.DATA_W(DATA_W)) u_read (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl_s),
    .busy_i   (busy_i),
    .result_i (result_i),
    .data_o   (data_o),
    .data_oe_o(data_oe_o)
  );
endmodule

// File: tb/adc_host_ctrl_test.sv
module adc_host_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce, cs_n, rc, a0, word, busy;
  logic [11:0] result;
  logic        start, short_cvt;
  logic [11:0] data, oe;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  logic exp_q [$];

  always #2 clk = ~clk;

  adc_host_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .chip_sel_ni(cs_n),
    .rd_cvt_i(rc), .byte_sel_i(a0), .word_mode_i(word), .busy_i(busy),
    .result_i(result), .start_o(start), .short_cvt_o(short_cvt),
    .data_o(data), .data_oe_o(oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int guard = 0;
    cyc(3);
    while ((busy || exp_q.size() != 0) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check("R1 start consumed", exp_q.size(), 0);
    cyc(4);
  endtask

  // engine model: busy for a length set by the latched conversion size
  initial begin
    busy = 1'b0;
    forever begin
      @(negedge clk);
      if (start) begin
        busy = 1'b1;
        repeat (short_cvt ? 14 : 20) @(negedge clk);
        busy = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (start && rst_n) begin
        starts++;
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R3/R4 unexpected start act=1 exp=0");
        end else begin
          check("R2 latched length", short_cvt, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic gap, lo_seen, bad, overlap;
    int   s0;
    ce = 0; cs_n = 1; rc = 1; a0 = 0; word = 1; result = 12'hA5C;
    rst_n = 0;
    cyc(3);
    check("R12 start in reset", start, 0);
    check("R12 oe in reset", oe, 0);
    @(negedge clk) rst_n = 1;
    cyc(4);
    check("R12 oe after reset", oe, 0);
    check("R12 short after reset", short_cvt, 0);

    // R1: chip enable last, 12-bit
    cs_n = 0; rc = 0; a0 = 0;
    cyc(5);
    check("R1 no start before ce", exp_q.size(), 0);
    exp_q.push_back(1'b0);
    ce = 1;
    cyc(4);
    rc = 1;
    wait_idle();
    // R7: whole word, address bit ignored
    check("R7 oe word", oe, 12'hFFF);
    check("R7 data word", data, 12'hA5C);
    a0 = 1;
    cyc(4);
    check("R7 a0 ignored oe", oe, 12'hFFF);
    check("R7 a0 ignored data", data, 12'hA5C);
    // R6: deselect gates the bus
    cs_n = 1;
    cyc(4);
    check("R6 cs high oe", oe, 0);
    check("R6 cs high data", data, 0);
    cs_n = 0; ce = 0;
    cyc(4);
    check("R6 ce low oe", oe, 0);

    // R1: chip select last, 8-bit; R3/R5 during busy
    result = 12'h3C7; word = 0; a0 = 1; cs_n = 1; ce = 1; rc = 0;
    cyc(5);
    exp_q.push_back(1'b1);
    cs_n = 0;
    cyc(3);
    rc = 1;
    cyc(4);
    check("R6 busy hides oe", oe, 0);
    a0 = 0;
    rc = 0;          // fresh start edge inside conversion: R3
    cyc(3);
    rc = 1;
    s0 = starts;
    wait_idle();
    check("R3 no restart", starts - s0, 0);
    check("R5 length held", short_cvt, 1);
    // R8: high byte
    check("R8 oe hi byte", oe, 12'hFF0);
    check("R8 data hi byte", data, 12'h3C0);
    // R10 / R9: switch to low byte
    gap = 0; lo_seen = 0; bad = 0; overlap = 0;
    a0 = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (oe == 12'h000) gap = 1;
      else if (oe == 12'h0FF) begin
        if (!gap) overlap = 1;
        lo_seen = 1;
      end else if (oe != 12'hFF0 || lo_seen) bad = 1;
    end
    check("R10 gap seen", gap, 1);
    check("R10 no overlap", overlap, 0);
    check("R10 no bad enable", bad, 0);
    check("R9 oe lo byte", oe, 12'h0FF);
    check("R9 data lo byte", data, 12'h007);

    // R1 read/convert last; R4 held condition
    a0 = 0; word = 1; result = 12'h5E1;
    s0 = starts;
    exp_q.push_back(1'b0);
    rc = 0;
    cyc(40);
    check("R4 single start", starts - s0, 1);
    check("R2 12-bit length", short_cvt, 0);
    rc = 1;
    wait_idle();
    check("R7 data after hold", data, 12'h5E1);

    // R11 stand-alone
    ce = 1; word = 1; a0 = 0; cs_n = 0; result = 12'h81F;
    s0 = starts;
    exp_q.push_back(1'b0);
    rc = 0;
    cyc(2);
    rc = 1;
    cyc(6);
    check("R11 busy hides oe", oe, 0);
    wait_idle();
    check("R11 one start", starts - s0, 1);
    check("R11 oe", oe, 12'hFFF);
    check("R11 data", data, 12'h81F);

    check("R3 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule